// File: doc/BRIEF.md
# Nestable Interrupt Priority Controller

This block decides which interrupt source a small CPU should take next, and it tracks the CPU's running priority level. Each source has a pending flag that an event pulse sets, an enable bit, and a 3-bit priority. The block picks the best pending, enabled source. It offers that source to the CPU only when the source's priority is strictly above the current 3-bit CPU level. When the CPU accepts the offer, the block pushes the old level onto an internal stack, raises the level, and clears the accepted source's pending flag. A return pulse pops the stack and restores the previous level.

A nesting-lock input changes how interrupt entry behaves. While the lock is set, every accepted interrupt raises the level to 7, which masks all other sources until a return. Software writes to the level are also ignored while the lock is set. Source priorities then only decide between requests that are pending together.

The control path is a two-state machine:
- `ST_IDLE`: no offer is outstanding.
- `ST_REQ`: an offer is being presented on the outputs.

Its transitions are:
- *raise* (`ST_IDLE`→`ST_REQ`): a qualifying source exists.
- *rearbitrate* (`ST_REQ`→`ST_REQ`): the offer is refreshed with the current winner each cycle.
- *accept* (`ST_REQ`→`ST_IDLE`): the CPU acknowledges the offer.
- *withdraw* (`ST_REQ`→`ST_IDLE`): no source qualifies any longer.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the CPU level is 0, no flag is pending, no offer is raised, and the overflow flag is clear.
- R2: A pulse on `irq_in[i]` sets pending bit `i` at that clock edge. The bit stays set until source `i` is accepted. If a new pulse and the accept clear land in the same cycle, the pulse wins and the bit stays set.
- R3: `int_req` rises one cycle after a source becomes pending, enabled, non-zero in priority and strictly above the CPU level. A source with priority 0, or with priority equal to or below the level, never raises it.
- R4: Among qualifying sources, the highest priority wins. On equal priority, the lowest index wins. `int_src` gives the winner's index and `int_prio` gives its priority.
- R5: While `int_req` is high, the offer is re-evaluated every cycle. It drops in the next cycle if no source qualifies any more, for example when the enable is removed.
- R6: `int_ack` with `int_req` high is an accept. With the lock clear, an accept pushes the current level, loads the offered priority, and clears the source's pending bit at the same edge. `int_req` is low in the following cycle.
- R7: With `nest_disable` high, an accept loads level 7. That level masks every source until a return pulse.
- R8: A level write (`lvl_wr_en`) loads `lvl_wr_data` only while `nest_disable` is low. While it is high, the write leaves the level unchanged.
- R9: A `rfi` pulse pops the most recent saved level into the CPU level. When the stack is empty, the level is left unchanged.
- R10: The stack holds 8 levels. An accept with the stack full sets a sticky `stack_ovf` flag, still loads the new level, and saves nothing. Only reset clears the flag.
- R11: When events coincide in one cycle, an accept beats a return, and a return beats a level write. The lower-ranked event in that cycle is dropped.
- R12: `int_ack` while `int_req` is low has no effect on the level or on the pending flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 8 | Per-source event pulses |
| src_en | input | 8 | Per-source enable |
| src_prio | input | 24 | Priorities, source i in bits [3i+2:3i] |
| nest_disable | input | 1 | Nesting lock: entry forces level 7, writes ignored |
| lvl_wr_en | input | 1 | Software write strobe for the CPU level |
| lvl_wr_data | input | 3 | Level value to write |
| int_ack | input | 1 | CPU accepts the current offer |
| rfi | input | 1 | Return-from-interrupt pulse |
| int_req | output | 1 | Offer outstanding |
| int_src | output | 3 | Index of the offered source |
| int_prio | output | 3 | Priority of the offered source |
| cpu_level | output | 3 | Current CPU priority level (readable) |
| pending | output | 8 | Pending flags |
| stack_ovf | output | 1 | Sticky saved-level stack overflow |

## Verification
The hardest state to reach is a full saved-level stack. Strictly rising priorities can nest only seven deep, so a ninth push cannot happen through preemption alone. The stimulus gets there by using software level writes (lock clear) to drop the level to 0 between accepts. The same source is then accepted nine times in a row, and the stack is unwound with eight returns to confirm the saved levels and the sticky flag.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int LVL_W = 3;
    localparam logic [LVL_W-1:0] LVL_TOP = '1;

    typedef logic [LVL_W-1:0] level_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_REQ  = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] set_i,
    input  logic [N_SRC-1:0] clr_i,
    output logic [N_SRC-1:0] pend_o
);

    genvar gi;
    generate
        for (gi = 0; gi < N_SRC; gi++) begin : g_flag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pend_o[gi] <= 1'b0;
                end else if (set_i[gi]) begin
                    pend_o[gi] <= 1'b1;
                end else if (clr_i[gi]) begin
                    pend_o[gi] <= 1'b0;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
    import irq_prio_pkg::*;
#(
    parameter int N_SRC = 8,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0]       pend_i,
    input  logic [N_SRC-1:0]       en_i,
    input  logic [N_SRC*LVL_W-1:0] prio_i,
    input  level_t                 level_i,
    output logic                   win_valid_o,
    output logic [IDX_W-1:0]       win_idx_o,
    output level_t                 win_prio_o
);

    logic [N_SRC-1:0] elig;
    level_t           prio_a [N_SRC];

    genvar gi;
    generate
        for (gi = 0; gi < N_SRC; gi++) begin : g_elig
            assign prio_a[gi] = prio_i[gi*LVL_W +: LVL_W];
            assign elig[gi]   = pend_i[gi] && en_i[gi] &&
                                (prio_a[gi] != '0) && (prio_a[gi] > level_i);
        end
    endgenerate

    always_comb begin
        win_valid_o = 1'b0;
        win_idx_o   = '0;
        win_prio_o  = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (elig[i] && (!win_valid_o || (prio_a[i] > win_prio_o))) begin
                win_valid_o = 1'b1;
                win_idx_o   = IDX_W'(i);
                win_prio_o  = prio_a[i];
            end
        end
    end

endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack
    import irq_prio_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   push_i,
    input  level_t push_data_i,
    input  logic   pop_i,
    output logic   top_valid_o,
    output level_t top_data_o,
    output logic   ovf_o
);

    level_t           mem [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic             full;

    assign full        = (cnt_q == CNT_W'(DEPTH));
    assign top_valid_o = (cnt_q != '0);
    assign top_data_o  = mem[PTR_W'(cnt_q - 1'b1)];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_o <= 1'b0;
        end else if (push_i) begin
            if (full) begin
                ovf_o <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (pop_i && top_valid_o) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push_i && !full) begin
            mem[PTR_W'(cnt_q)] <= push_data_i;
        end
    end

    a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);

    a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));

    a_r9_empty_pop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !top_valid_o) |=> (cnt_q == '0));

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int STACK_DEPTH = 8,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_SRC-1:0]       irq_in,
    input  logic [N_SRC-1:0]       src_en,
    input  logic [N_SRC*LVL_W-1:0] src_prio,
    input  logic                   nest_disable,
    input  logic                   lvl_wr_en,
    input  logic [LVL_W-1:0]       lvl_wr_data,
    input  logic                   int_ack,
    input  logic                   rfi,
    output logic                   int_req,
    output logic [IDX_W-1:0]       int_src,
    output logic [LVL_W-1:0]       int_prio,
    output logic [LVL_W-1:0]       cpu_level,
    output logic [N_SRC-1:0]       pending,
    output logic                   stack_ovf
);

    ctl_state_e       state_q, state_d;
    level_t           level_q, level_d;
    logic [IDX_W-1:0] sel_src_q;
    level_t           sel_prio_q;

    logic             win_valid;
    logic [IDX_W-1:0] win_idx;
    level_t           win_prio;

    logic             accept, pop_fire, sw_write;
    logic [N_SRC-1:0] clr_vec;
    logic             stk_valid;
    level_t           stk_top;

    irq_pend_bank #(.N_SRC(N_SRC)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (irq_in),
        .clr_i  (clr_vec),
        .pend_o (pending)
    );

    irq_prio_arbiter #(.N_SRC(N_SRC)) u_arb (
        .pend_i      (pending),
        .en_i        (src_en),
        .prio_i      (src_prio),
        .level_i     (level_q),
        .win_valid_o (win_valid),
        .win_idx_o   (win_idx),
        .win_prio_o  (win_prio)
    );

    irq_level_stack #(.DEPTH(STACK_DEPTH)) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (accept),
        .push_data_i (level_q),
        .pop_i       (pop_fire),
        .top_valid_o (stk_valid),
        .top_data_o  (stk_top),
        .ovf_o       (stack_ovf)
    );

    // Event ranking: accept, then return, then software write.
    assign accept   = (state_q == ST_REQ) && int_ack;
    assign pop_fire = !accept && rfi && stk_valid;
    assign sw_write = !accept && !rfi && lvl_wr_en && !nest_disable;

    always_comb begin
        clr_vec = '0;
        if (accept) begin
            clr_vec[sel_src_q] = 1'b1;
        end
    end

    always_comb begin
        level_d = level_q;
        if (accept) begin
            level_d = nest_disable ? LVL_TOP : sel_prio_q;
        end else if (pop_fire) begin
            level_d = stk_top;
        end else if (sw_write) begin
            level_d = lvl_wr_data;
        end
    end

    // Next-state logic: raise, rearbitrate, accept, withdraw.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (win_valid) begin
                    state_d = ST_REQ;
                end
            end
            ST_REQ: begin
                if (accept) begin
                    state_d = ST_IDLE;
                end else if (!win_valid) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            level_q    <= '0;
            sel_src_q  <= '0;
            sel_prio_q <= '0;
        end else begin
            state_q <= state_d;
            level_q <= level_d;
            if (state_d == ST_REQ) begin
                sel_src_q  <= win_idx;
                sel_prio_q <= win_prio;
            end
        end
    end

    always_comb begin
        int_req   = (state_q == ST_REQ);
        int_src   = sel_src_q;
        int_prio  = sel_prio_q;
        cpu_level = level_q;
    end

    a_r3_offer_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> (int_prio != '0));

    a_r6_accept_loads_prio: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && int_ack && !nest_disable) |=> (cpu_level == $past(int_prio)));

    a_r6_offer_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && int_ack) |=> !int_req);

    a_r7_lock_level: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && int_ack && nest_disable) |=> (cpu_level == LVL_TOP));

    a_r8_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (nest_disable && lvl_wr_en && !int_ack && !rfi) |=> $stable(cpu_level));

    a_r12_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_req && int_ack && !rfi && !lvl_wr_en) |=> $stable(cpu_level));

endmodule

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] irq_in = '0;
    logic [N-1:0] src_en = '1;
    logic [3*N-1:0] src_prio = '0;
    logic         nest_disable = 1'b0;
    logic         lvl_wr_en = 1'b0;
    logic [2:0]   lvl_wr_data = '0;
    logic         int_ack = 1'b0;
    logic         rfi = 1'b0;
    logic         int_req;
    logic [2:0]   int_src;
    logic [2:0]   int_prio;
    logic [2:0]   cpu_level;
    logic [N-1:0] pending;
    logic         stack_ovf;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string cur = "R1";

    // reference model state
    int m_level, m_pend, m_ovf, m_req, m_src, m_prio;
    int stk[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_prio_ctrl uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .src_en(src_en),
        .src_prio(src_prio), .nest_disable(nest_disable),
        .lvl_wr_en(lvl_wr_en), .lvl_wr_data(lvl_wr_data),
        .int_ack(int_ack), .rfi(rfi), .int_req(int_req), .int_src(int_src),
        .int_prio(int_prio), .cpu_level(cpu_level), .pending(pending),
        .stack_ovf(stack_ovf)
    );

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_level = 0; m_pend = 0; m_ovf = 0; m_req = 0; m_src = 0; m_prio = 0;
        stk.delete();
    endtask

    task automatic model_step();
        int found = 0, bi = 0, bp = 0, p;
        int n_level = m_level, n_pend, clr = 0;
        bit acc;
        for (int i = 0; i < N; i++) begin
            p = src_prio[3*i +: 3];
            if (m_pend[i] && src_en[i] && p != 0 && p > m_level &&
                (!found || p > bp)) begin
                found = 1; bi = i; bp = p;
            end
        end
        acc = m_req && int_ack;
        if (acc) begin
            clr = 1 << m_src;
            if (stk.size() < 8) stk.push_back(m_level); else m_ovf = 1;
            n_level = nest_disable ? 7 : m_prio;
        end else if (rfi) begin
            if (stk.size() > 0) n_level = stk.pop_back();
        end else if (lvl_wr_en && !nest_disable) begin
            n_level = lvl_wr_data;
        end
        n_pend = (m_pend & ~clr) | irq_in;
        if (!acc && found) begin
            m_req = 1; m_src = bi; m_prio = bp;
        end else begin
            m_req = 0;
        end
        m_pend = n_pend & 8'hFF;
        m_level = n_level;
    endtask

    task automatic compare();
        chk(cur, "int_req", int_req, m_req);
        chk(cur, "cpu_level", cpu_level, m_level);
        chk(cur, "pending", pending, m_pend);
        chk(cur, "stack_ovf", stack_ovf, m_ovf);
        if (m_req) begin
            chk(cur, "int_src", int_src, m_src);
            chk(cur, "int_prio", int_prio, m_prio);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        #1;
        compare();
        irq_in = '0; int_ack = 0; rfi = 0; lvl_wr_en = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (2) @(posedge clk);
        model_reset();
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        int pr[8] = '{2, 5, 5, 0, 3, 1, 6, 4};
        for (int i = 0; i < N; i++) src_prio[3*i +: 3] = 3'(pr[i]);
        do_reset();
        #1;
        cur = "R1";
        chk("R1", "reset level", cpu_level, 0);
        chk("R1", "reset pending", pending, 0);
        chk("R1", "reset req", int_req, 0);
        chk("R1", "reset ovf", stack_ovf, 0);

        cur = "R2"; irq_in = 8'h08; cyc();
        chk("R2", "pending set", pending, 8'h08);
        cur = "R3"; cyc(); cyc();
        chk("R3", "prio0 no request", int_req, 0);

        cur = "R4"; irq_in = 8'h06; cyc(); cyc();
        chk("R4", "tie req", int_req, 1);
        chk("R4", "tie lowest index", int_src, 1);
        chk("R4", "winner prio", int_prio, 5);

        cur = "R6"; int_ack = 1; cyc();
        chk("R6", "level loaded", cpu_level, 5);
        chk("R6", "pending cleared", pending, 8'h0C);
        chk("R6", "req dropped", int_req, 0);
        cur = "R3"; cyc();
        chk("R3", "equal prio blocked", int_req, 0);

        cur = "R5"; irq_in = 8'h40; cyc(); cyc();
        chk("R5", "preempt src", int_src, 6);
        src_en[6] = 0; cyc();
        chk("R5", "withdraw", int_req, 0);
        src_en[6] = 1; cyc(); cyc();
        cur = "R6"; int_ack = 1; cyc();
        chk("R6", "nested level", cpu_level, 6);

        cur = "R9"; rfi = 1; cyc();
        chk("R9", "pop to 5", cpu_level, 5);
        rfi = 1; cyc();
        chk("R9", "pop to 0", cpu_level, 0);
        rfi = 1; cyc();
        chk("R9", "empty pop hold", cpu_level, 0);

        cur = "R11"; int_ack = 1; rfi = 1; lvl_wr_en = 1; lvl_wr_data = 3; cyc();
        chk("R11", "accept beats others", cpu_level, 5);
        rfi = 1; lvl_wr_en = 1; lvl_wr_data = 6; cyc();
        chk("R11", "return beats write", cpu_level, 0);

        cur = "R8"; lvl_wr_en = 1; lvl_wr_data = 4; cyc();
        chk("R8", "write applies", cpu_level, 4);
        nest_disable = 1; lvl_wr_en = 1; lvl_wr_data = 1; cyc();
        chk("R8", "locked write ignored", cpu_level, 4);

        cur = "R12"; nest_disable = 0; int_ack = 1; cyc();
        chk("R12", "stray ack level", cpu_level, 4);
        chk("R12", "stray ack pending", pending, 8'h08);

        cur = "R7"; lvl_wr_en = 1; lvl_wr_data = 0; cyc();
        nest_disable = 1; irq_in = 8'h11; cyc(); cyc();
        chk("R7", "locked arbitration src", int_src, 4);
        int_ack = 1; cyc();
        chk("R7", "level forced 7", cpu_level, 7);
        irq_in = 8'h40; cyc(); cyc(); cyc();
        chk("R7", "masked at 7", int_req, 0);
        rfi = 1; cyc();
        chk("R7", "unmask on return", cpu_level, 0);
        cyc();
        chk("R7", "offer after return", int_src, 6);
        nest_disable = 0;

        cur = "R10"; do_reset();
        for (int k = 0; k < 9; k++) begin
            lvl_wr_en = 1; lvl_wr_data = 0; cyc();
            irq_in = 8'h40; cyc(); cyc();
            int_ack = 1; cyc();
            chk("R10", "ovf after push", stack_ovf, (k == 8) ? 1 : 0);
        end
        chk("R10", "level after full push", cpu_level, 6);
        for (int k = 0; k < 8; k++) begin
            rfi = 1; cyc();
        end
        chk("R10", "unwound level", cpu_level, 0);
        chk("R10", "ovf sticky", stack_ovf, 1);

        cur = "R2"; irq_in = 8'h40; cyc(); cyc();
        int_ack = 1; irq_in = 8'h40; cyc();
        chk("R2", "set beats clear", pending, 8'h40);
        cyc(); cyc();

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule